// File: doc/BRIEF.md
# Threshold Offset Register Loader

This block keeps the two threshold values that a dual-clock queue's almost-empty and almost-full flag logic compares against. One is the empty-side offset and the other is the full-side offset. Each is a 12-bit register. There is no address. Software or a controller holds the load strobe low and presents words on the write data bus. Each qualified write-clock edge stores the word into whichever register a one-bit sequence pointer selects, and the pointer then moves on. The order is empty offset, then full offset, then back to the empty offset. A load session can stop after any register and continue later from where it left off.

Readback works the same way in the read-clock domain. It has its own pointer and a registered output bus, and it never disturbs the write pointer. The registers live in the write domain, where the almost-full comparison can use them directly. A toggle handshake carries a held snapshot of both values into the read domain. That copy feeds readback and the almost-empty comparison. After reset, both registers hold a default that depends on the queue depth, and both pointers select the empty offset.

Top module: `ofs_loader`

## Requirements
- R1: Each register is OFS_W (12) bits wide and loads from wdata[11:0] only. Bits wdata[DATA_W-1:12] have no effect on the stored value.
- R2: While load_n=0 and wen_n=0, each rising wclk edge stores wdata[11:0] into the selected register. The register is visible on wr_empty_ofs or wr_full_ofs right after that edge. The selection order is empty offset first, then full offset, then back to empty.
- R3: While load_n=0 and wen_n=1, a wclk edge writes no register and does not advance the write pointer.
- R4: While load_n=1, no register is written and the write pointer keeps its position. The next load session therefore continues with the register that follows the last one written.
- R5: While load_n=0 and ren_n=0, each rising rclk edge places the register chosen by a separate read pointer on rdata. The value sits in rdata[11:0] and rdata[DATA_W-1:12] is zero. The order is empty offset first, then full offset, then back to empty. The read pointer is independent of the write pointer.
- R6: While load_n=1 or ren_n=1, rdata holds its value and the read pointer does not advance.
- R7: While rst_n is low, both registers take the default min(DEPTH/8,128)-1. That is 31 for depth 256, 63 for depth 512 and 127 for depth 1024 and above. rdata clears to zero.
- R8: Reset returns both the write pointer and the read pointer to the empty offset.
- R9: After the last register write, rd_empty_ofs and rd_full_ofs take the written values within a few rclk cycles. The snapshot being carried stays stable while a transfer is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Synchronous active-low reset, held across several edges of both clocks |
| load_n | input | 1 | Active-low strobe that selects offset-register access |
| wen_n | input | 1 | Active-low write enable, sampled on wclk |
| ren_n | input | 1 | Active-low read enable, sampled on rclk |
| wdata | input | DATA_W | Write data bus; bits [11:0] carry the offset |
| rdata | output | DATA_W | Registered readback bus in the rclk domain |
| wr_empty_ofs | output | OFS_W | Empty-side offset, write domain |
| wr_full_ofs | output | OFS_W | Full-side offset, write domain |
| rd_empty_ofs | output | OFS_W | Empty-side offset copy, read domain |
| rd_full_ofs | output | OFS_W | Full-side offset copy, read domain |

## Verification
The main instance is built with DEPTH=256, DATA_W=18 and OFS_W=12. These values give the smallest default of 31 and leave six upper data bits that must be ignored on load and zeroed on readback. A second instance is built with DEPTH=4096 so that the default is seen to cap at 127. The write clock runs at 4 ns and the read clock at 6 ns. This makes the snapshot transfer cross between unrelated edges. It also lets write sessions and readback sessions be interrupted at different pointer positions.

// File: rtl/ofs_loader_pkg.sv
// Package: shared types and the reset-default rule for the offset loader.
// Assumes depth is a power of two of at least 8.
package ofs_loader_pkg;

    // Which of the two offset registers a sequence pointer selects
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    // Default offset: one eighth of depth, capped at 128, minus one
    function automatic int unsigned default_offset(input int unsigned depth);
        int unsigned eighth;
        eighth = depth / 8;
        if (eighth > 128) eighth = 128;
        if (eighth == 0)  eighth = 1;
        return eighth - 1;
    endfunction

endpackage

// File: rtl/ofs_seq_ptr.sv
// Module: one-bit auto-advancing sequence pointer.
// It starts at the empty-offset register and toggles on each advance.
// Assumes adv is synchronous to clk.
module ofs_seq_ptr
    import ofs_loader_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     adv,
    output ofs_sel_e sel
);

    // Pointer state: reset to empty, toggle on advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= SEL_EMPTY;
        else if (adv)
            sel <= (sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end

    // R3 / R6: without an advance the pointer does not move
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(sel));

    // R2 / R5: every advance moves to the other register
    assert_ptr_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (sel != $past(sel)));

    // R8: reset leaves the pointer on the empty offset
    assert_ptr_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (sel == SEL_EMPTY));

endmodule

// File: rtl/ofs_wr_bank.sv
// Module: write-domain bank of the two offset registers.
// It loads from the low OFS_W bits of wdata when load_n and wen_n are both low,
// at the register chosen by its own sequence pointer.
// Assumes DATA_W >= OFS_W. wr_evt pulses for one cycle per stored word.
module ofs_wr_bank
    import ofs_loader_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs,
    output logic              wr_evt
);

    localparam int unsigned      DEF_INT = default_offset(DEPTH);
    localparam logic [OFS_W-1:0] DEF_OFS = OFS_W'(DEF_INT);
    localparam int unsigned      N_REGS  = 2;

    ofs_sel_e          sel;
    logic              fire;
    logic [N_REGS-1:0] hit;

    // Qualified load strobe
    assign fire   = !load_n && !wen_n;
    assign wr_evt = fire;

    // Per-register write select, indexed by the pointer encoding
    assign hit = {fire && (sel == SEL_FULL), fire && (sel == SEL_EMPTY)};

    ofs_seq_ptr u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fire),
        .sel   (sel)
    );

    // One register per generate slice: 0 = empty offset, 1 = full offset
    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
        logic [OFS_W-1:0] val_q;

        // Store the low data bits when this slice is selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= DEF_OFS;
            else if (hit[gi])
                val_q <= wdata[OFS_W-1:0];
        end
    end

    assign empty_ofs = g_reg[0].val_q;
    assign full_ofs  = g_reg[1].val_q;

    if (DATA_W > OFS_W) begin : g_hi
        logic unused_hi_bits;
        assign unused_hi_bits = ^wdata[DATA_W-1:OFS_W];
    end

    // R4 / R3: outside a qualified load both registers hold
    assert_reg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || wen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R2: a qualified load changes at most one register
    assert_one_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ($stable(empty_ofs) || $stable(full_ofs)));

    // R7: reset applies the depth default
    assert_reset_def_R7: assert property (@(posedge clk)
        !rst_n |=> ((empty_ofs == DEF_OFS) && (full_ofs == DEF_OFS)));

endmodule

// File: rtl/ofs_cdc_hold.sv
// Module: carries the two offsets from the write domain to the read domain.
// A held snapshot and a toggle request/acknowledge pair do the transfer, with
// two-flop synchronizers on each direction.
// A write made during a transfer is recorded and sent afterwards.
// Assumes rst_n is held across several edges of both clocks.
module ofs_cdc_hold
    import ofs_loader_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned OFS_W = 12
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             src_evt,
    input  logic [OFS_W-1:0] src_empty,
    input  logic [OFS_W-1:0] src_full,
    output logic [OFS_W-1:0] dst_empty,
    output logic [OFS_W-1:0] dst_full
);

    localparam int unsigned      DEF_INT = default_offset(DEPTH);
    localparam logic [OFS_W-1:0] DEF_OFS = OFS_W'(DEF_INT);

    // Write-domain state
    logic             pending;
    logic             req;
    logic             ack_s1, ack_s2;
    logic [OFS_W-1:0] snap_empty, snap_full;
    logic             busy, launch;

    // Read-domain state
    logic             req_s1, req_s2;
    logic             ack;

    assign busy   = (req != ack_s2);
    assign launch = pending && !busy;

    // Capture the snapshot and raise the request when idle
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            pending    <= 1'b0;
            req        <= 1'b0;
            snap_empty <= DEF_OFS;
            snap_full  <= DEF_OFS;
        end else begin
            if (launch) begin
                snap_empty <= src_empty;
                snap_full  <= src_full;
                req        <= ~req;
            end
            pending <= src_evt || (pending && !launch);
        end
    end

    // Bring the acknowledge back into the write domain
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= ack;
            ack_s2 <= ack_s1;
        end
    end

    // Bring the request into the read domain
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
        end else begin
            req_s1 <= req;
            req_s2 <= req_s1;
        end
    end

    // Take the held snapshot and acknowledge
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            dst_empty <= DEF_OFS;
            dst_full  <= DEF_OFS;
        end else if (req_s2 != ack) begin
            ack       <= req_s2;
            dst_empty <= snap_empty;
            dst_full  <= snap_full;
        end
    end

    // R9: the snapshot never moves while a transfer is in flight
    assert_snap_stable_R9: assert property (@(posedge wclk) disable iff (!rst_n)
        busy |=> ($stable(snap_empty) && $stable(snap_full)));

    // R9: the read-domain copy only changes on a new request
    assert_dst_hold_R9: assert property (@(posedge rclk) disable iff (!rst_n)
        (req_s2 == ack) |=> ($stable(dst_empty) && $stable(dst_full)));

endmodule

// File: rtl/ofs_rd_port.sv
// Module: read-domain readback of the offset registers.
// It has its own sequence pointer and drives a registered, zero-extended output.
// Assumes the offset copies it reads are already in the rclk domain.
module ofs_rd_port
    import ofs_loader_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              ren_n,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] rdata
);

    ofs_sel_e         sel;
    logic             fire;
    logic [OFS_W-1:0] pick;

    assign fire = !load_n && !ren_n;
    assign pick = (sel == SEL_FULL) ? full_ofs : empty_ofs;

    ofs_seq_ptr u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (fire),
        .sel   (sel)
    );

    // Output register: clear on reset, load the selected offset on readback
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (fire)
            rdata <= DATA_W'(pick);
    end

    // R6: rdata holds outside a qualified readback
    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || ren_n) |=> $stable(rdata));

    if (DATA_W > OFS_W) begin : g_pad_chk
        // R5: the bus bits above the offset width stay zero
        assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            fire |=> (rdata[DATA_W-1:OFS_W] == '0));
    end

endmodule

// File: rtl/ofs_loader.sv
// Module: top of the threshold offset loader.
// Holds the write-domain bank and the read-domain readback port, with the
// snapshot crossing between them.
// Assumes a readback and a register write never overlap, and that rst_n is
// held across several edges of both clocks.
module ofs_loader #(
    parameter int unsigned DEPTH  = 1024,
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [OFS_W-1:0]  wr_empty_ofs,
    output logic [OFS_W-1:0]  wr_full_ofs,
    output logic [OFS_W-1:0]  rd_empty_ofs,
    output logic [OFS_W-1:0]  rd_full_ofs
);

    logic wr_evt;

    ofs_wr_bank #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_bank (
        .clk       (wclk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wen_n     (wen_n),
        .wdata     (wdata),
        .empty_ofs (wr_empty_ofs),
        .full_ofs  (wr_full_ofs),
        .wr_evt    (wr_evt)
    );

    ofs_cdc_hold #(
        .DEPTH (DEPTH),
        .OFS_W (OFS_W)
    ) u_cdc (
        .wclk      (wclk),
        .rclk      (rclk),
        .rst_n     (rst_n),
        .src_evt   (wr_evt),
        .src_empty (wr_empty_ofs),
        .src_full  (wr_full_ofs),
        .dst_empty (rd_empty_ofs),
        .dst_full  (rd_full_ofs)
    );

    ofs_rd_port #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_rd (
        .clk       (rclk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .ren_n     (ren_n),
        .empty_ofs (rd_empty_ofs),
        .full_ofs  (rd_full_ofs),
        .rdata     (rdata)
    );

endmodule

// File: tb/ofs_loader_tb_top.sv
// Directed bench for the offset loader: one task per scenario.
module ofs_loader_tb_top;

    localparam int unsigned DATA_W = 18;
    localparam int unsigned OFS_W  = 12;

    logic              wclk = 1'b0;
    logic              rclk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_n = 1'b1;
    logic              wen_n = 1'b1;
    logic              ren_n = 1'b1;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata, rdata_b;
    logic [OFS_W-1:0]  we_o, wf_o, re_o, rf_o;
    logic [OFS_W-1:0]  we_b, wf_b, re_b, rf_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 wclk = ~wclk;   // 250 MHz write clock
    always #3 rclk = ~rclk;   // unrelated read clock

    ofs_loader #(.DEPTH(256), .DATA_W(DATA_W), .OFS_W(OFS_W)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(load_n),
        .wen_n(wen_n), .ren_n(ren_n), .wdata(wdata), .rdata(rdata),
        .wr_empty_ofs(we_o), .wr_full_ofs(wf_o),
        .rd_empty_ofs(re_o), .rd_full_ofs(rf_o)
    );

    ofs_loader #(.DEPTH(4096), .DATA_W(DATA_W), .OFS_W(OFS_W)) dut_big_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(1'b1),
        .wen_n(1'b1), .ren_n(1'b1), .wdata('0), .rdata(rdata_b),
        .wr_empty_ofs(we_b), .wr_full_ofs(wf_b),
        .rd_empty_ofs(re_b), .rd_full_ofs(rf_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_edge(input logic ld, input logic we, input logic [DATA_W-1:0] d);
        @(negedge wclk);
        load_n = ld; wen_n = we; wdata = d;
        @(posedge wclk);
        #1;
    endtask

    task automatic wr_idle();
        @(negedge wclk);
        load_n = 1'b1; wen_n = 1'b1;
    endtask

    task automatic rd_edge(input logic ld, input logic re);
        @(negedge rclk);
        load_n = ld; ren_n = re;
        @(posedge rclk);
        #1;
    endtask

    task automatic rd_idle();
        @(negedge rclk);
        load_n = 1'b1; ren_n = 1'b1;
    endtask

    task automatic settle();
        repeat (12) @(posedge wclk);
        repeat (12) @(posedge rclk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        #1;
    endtask

    // R7: depth-dependent defaults and cleared readback
    task automatic t_reset_defaults();
        do_reset();
        check("R7 wr_empty default 256", 32'(we_o), 32'h01F);
        check("R7 wr_full default 256",  32'(wf_o), 32'h01F);
        check("R7 rd_empty default 256", 32'(re_o), 32'h01F);
        check("R7 rd_full default 256",  32'(rf_o), 32'h01F);
        check("R7 rdata cleared",        32'(rdata), 32'h0);
        check("R7 empty default capped", 32'(we_b), 32'h07F);
        check("R7 full default capped",  32'(wf_b), 32'h07F);
        check("R7 rd copy capped",       32'({re_b, rf_b}), 32'h07F07F);
    endtask

    // R2: empty, full, wrap to empty
    task automatic t_write_order();
        wr_edge(1'b0, 1'b0, 18'h00A5B);
        check("R2 first edge empty", 32'(we_o), 32'hA5B);
        check("R2 first edge full untouched", 32'(wf_o), 32'h01F);
        wr_edge(1'b0, 1'b0, 18'h00123);
        check("R2 second edge full", 32'(wf_o), 32'h123);
        check("R2 second edge empty kept", 32'(we_o), 32'hA5B);
        wr_edge(1'b0, 1'b0, 18'h00456);
        check("R2 third edge wraps to empty", 32'(we_o), 32'h456);
        check("R2 third edge full kept", 32'(wf_o), 32'h123);
        wr_idle();
    endtask

    // R3: wen_n high freezes registers and pointer
    task automatic t_freeze();
        for (int i = 0; i < 3; i++) wr_edge(1'b0, 1'b1, 18'h00FFF);
        check("R3 empty frozen", 32'(we_o), 32'h456);
        check("R3 full frozen",  32'(wf_o), 32'h123);
        wr_edge(1'b0, 1'b0, 18'h00789);
        check("R3 pointer did not advance", 32'(wf_o), 32'h789);
        check("R3 empty still kept", 32'(we_o), 32'h456);
        wr_idle();
    endtask

    // R4: interrupted sessions continue in sequence
    task automatic t_session_resume();
        wr_edge(1'b0, 1'b0, 18'h00321);
        check("R4 session one writes empty", 32'(we_o), 32'h321);
        wr_idle();
        wr_edge(1'b1, 1'b0, 18'h00ABC);
        wr_edge(1'b1, 1'b0, 18'h00ABC);
        check("R4 load high writes nothing", 32'({we_o, wf_o}), 32'h321789);
        wr_idle();
        wr_edge(1'b0, 1'b0, 18'h00654);
        check("R4 session two resumes at full", 32'(wf_o), 32'h654);
        wr_idle();
    endtask

    // R1: only the low data bits are stored
    task automatic t_upper_bits();
        wr_edge(1'b0, 1'b0, 18'h3F0F0);
        check("R1 empty drops upper bits", 32'(we_o), 32'h0F0);
        wr_edge(1'b0, 1'b0, 18'h2A5A5);
        check("R1 full drops upper bits", 32'(wf_o), 32'h5A5);
        wr_idle();
    endtask

    // R9: read-domain copies follow
    task automatic t_crossing();
        settle();
        check("R9 rd_empty follows", 32'(re_o), 32'h0F0);
        check("R9 rd_full follows",  32'(rf_o), 32'h5A5);
    endtask

    // R5, R6: readback order, independence, holding
    task automatic t_readback();
        rd_edge(1'b0, 1'b0);
        check("R5 first readback empty", 32'(rdata), 32'h000F0);
        rd_edge(1'b0, 1'b0);
        check("R5 second readback full", 32'(rdata), 32'h005A5);
        rd_edge(1'b0, 1'b0);
        check("R5 third readback wraps", 32'(rdata), 32'h000F0);
        rd_idle();
        rd_edge(1'b0, 1'b1);
        rd_edge(1'b0, 1'b1);
        check("R6 ren high holds rdata", 32'(rdata), 32'h000F0);
        rd_edge(1'b1, 1'b0);
        check("R6 load high holds rdata", 32'(rdata), 32'h000F0);
        rd_edge(1'b0, 1'b0);
        check("R6 read pointer did not advance", 32'(rdata), 32'h005A5);
        rd_idle();
        wr_edge(1'b0, 1'b0, 18'h00111);   // write pointer now at full
        wr_idle();
        settle();
        rd_edge(1'b0, 1'b0);
        check("R5 read pointer independent", 32'(rdata), 32'h00111);
        rd_idle();
    endtask

    // R8: reset returns both pointers to empty
    task automatic t_reset_ptr();
        do_reset();
        check("R7 rdata cleared again", 32'(rdata), 32'h0);
        wr_edge(1'b0, 1'b0, 18'h00777);
        check("R8 write pointer back at empty", 32'(we_o), 32'h777);
        check("R8 full keeps default", 32'(wf_o), 32'h01F);
        wr_idle();
        settle();
        rd_edge(1'b0, 1'b0);
        check("R8 read pointer back at empty", 32'(rdata), 32'h00777);
        rd_idle();
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_defaults();
        t_write_order();
        t_freeze();
        t_session_resume();
        t_upper_bits();
        t_crossing();
        t_readback();
        t_reset_ptr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule